// File: doc/BRIEF.md
# Programming Unlock Guard

This block protects a non-volatile memory controller from stray program and erase commands. The host must first write a fixed sequence of key bytes to a dedicated key register. Only when every byte has arrived in the right order does the guard arm itself. The next program or erase request then gets a single-cycle permit pulse, and the guard returns to its locked state. Every further operation needs a new key sequence.

Any departure from the protocol trips a sticky lockout. This covers a wrong key byte, an extra key byte while already armed, and a program or erase request without a full unlock. Once tripped, no further permit is ever issued until reset. Read requests are never gated: they pass straight through in the same cycle, whatever state the guard is in.

A status vector reports the lockout flag, the armed flag and how many key bytes have matched so far.

Top module: `flash_key_guard`

## Requirements
- R1: After reset, `permit_o` is 0, `lockout_o` is 0 and `status_o` is all zeros.
- R2: With the default key, a key write (`key_wr_i`=1) of 0xA5 moves `status_o` to 3'b001 (one byte matched). A following key write of 0xF1 moves it to 3'b010 (armed). Each change is visible one cycle after the write. The encoding is bit 2 = lockout, bit 1 = armed, and bits 0 and up = count of key bytes matched.
- R3: A key write whose byte differs from the expected next key byte sets the lockout one cycle later, and `status_o` becomes 3'b100. A key write while already armed does the same.
- R4: A program/erase request (`op_req_i`=1) while not armed, including midway through the key sequence, sets the lockout one cycle later and produces no permit.
- R5: A request while armed and not locked out raises `permit_o` for exactly one cycle, the cycle after the request. It also returns `status_o` to 3'b000, so the next request needs a new key sequence.
- R6: Once set, the lockout stays set until reset. While it is set, key writes and requests change nothing and `permit_o` stays 0.
- R7: `rd_go_o` equals `rd_req_i` in the same cycle, in every state, including lockout.
- R8: Cycles with neither a key write nor a request leave `status_o` unchanged. This includes cycles that carry reads between the two key bytes.
- R9: When a key write and a request arrive in the same cycle, the request is evaluated against the current state and the key byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr_i | input | 1 | Host write strobe for the key register |
| key_data_i | input | DATA_W | Byte written to the key register |
| op_req_i | input | 1 | Program or erase request strobe |
| rd_req_i | input | 1 | Memory read request |
| rd_go_o | output | 1 | Read forwarded to the memory, never gated |
| permit_o | output | 1 | One-cycle permission for the requested operation |
| lockout_o | output | 1 | Sticky lockout flag |
| status_o | output | IDX_W+2 | {lockout, armed, matched-byte count} |

## Verification
The bench builds the guard with its defaults: 8-bit data and a two-byte key of 0xA5 then 0xF1. With these values a one-bit match counter covers every point of the sequence. Random bytes drawn mostly from the two key values reach full unlocks, partial sequences broken by wrong bytes, and requests at each stage, all within a few cycles. Periodic resets let the random run leave lockout and cover many sequences, alongside directed cases for same-cycle key-and-request and for repeated requests after one unlock.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PARTIAL = 2'd1,
        SEQ_OPEN    = 2'd2
    } seq_mode_e;

endpackage

// File: rtl/flk_key_match.sv
module flk_key_match #(
    parameter int                        DATA_W  = 8,
    parameter int                        KEY_LEN = 2,
    parameter int                        IDX_W   = 1,
    parameter logic [KEY_LEN*DATA_W-1:0] KEYS    = 16'hF1A5
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              match_o
);

    logic [DATA_W-1:0] expect_tbl [KEY_LEN];

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
        assign expect_tbl[g] = KEYS[g*DATA_W +: DATA_W];
    end

    always_comb begin
        match_o = 1'b0;
        for (int i = 0; i < KEY_LEN; i++) begin
            if (idx_i == IDX_W'(i)) begin
                match_o = (data_i == expect_tbl[i]);
            end
        end
    end

endmodule

// File: rtl/flk_seq.sv
module flk_seq
    import flk_pkg::*;
#(
    parameter int KEY_LEN = 2,
    parameter int IDX_W   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr_i,
    input  logic             key_match_i,
    input  logic             op_req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             op_ok_o,
    output logic             armed_o,
    output logic             lockout_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);

    typedef struct packed {
        seq_mode_e        mode;
        logic [IDX_W-1:0] idx;
        logic             lockout;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       op_ok;

    always_comb begin
        st_d  = st_q;
        op_ok = op_req_i && (st_q.mode == SEQ_OPEN) && !st_q.lockout;
        if (!st_q.lockout) begin
            if (op_req_i) begin
                st_d.mode = SEQ_IDLE;
                st_d.idx  = '0;
                if (!op_ok) begin
                    st_d.lockout = 1'b1;
                end
            end else if (key_wr_i) begin
                if (st_q.mode == SEQ_OPEN || !key_match_i) begin
                    st_d.mode    = SEQ_IDLE;
                    st_d.idx     = '0;
                    st_d.lockout = 1'b1;
                end else if (st_q.idx == LAST_IDX) begin
                    st_d.mode = SEQ_OPEN;
                    st_d.idx  = '0;
                end else begin
                    st_d.mode = SEQ_PARTIAL;
                    st_d.idx  = st_q.idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: SEQ_IDLE, idx: '0, lockout: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o     = st_q.idx;
    assign op_ok_o   = op_ok;
    assign armed_o   = (st_q.mode == SEQ_OPEN);
    assign lockout_o = st_q.lockout;

    assert_bad_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr_i && !op_req_i && !st_q.lockout && !key_match_i |=> st_q.lockout);

    assert_early_op_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_req_i && st_q.mode != SEQ_OPEN |=> st_q.lockout);

    assert_lockout_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lockout |=> st_q.lockout);

    assert_open_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_req_i && st_q.mode == SEQ_OPEN |=> st_q.mode == SEQ_IDLE);

endmodule

// File: rtl/flk_permit.sv
module flk_permit (
    input  logic clk,
    input  logic rst_n,
    input  logic op_ok_i,
    output logic permit_o
);

    logic permit_d, permit_q;

    always_comb begin
        permit_d = op_ok_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            permit_q <= 1'b0;
        end else begin
            permit_q <= permit_d;
        end
    end

    assign permit_o = permit_q;

    assert_permit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        permit_q |=> !permit_q);

endmodule

// File: rtl/flash_key_guard.sv
module flash_key_guard #(
    parameter int                        DATA_W  = 8,
    parameter int                        KEY_LEN = 2,
    parameter logic [KEY_LEN*DATA_W-1:0] KEYS    = 16'hF1A5,
    parameter int                        IDX_W   = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_data_i,
    input  logic              op_req_i,
    input  logic              rd_req_i,
    output logic              rd_go_o,
    output logic              permit_o,
    output logic              lockout_o,
    output logic [IDX_W+1:0]  status_o
);

    logic [IDX_W-1:0] idx;
    logic             key_match;
    logic             op_ok;
    logic             armed;
    logic             lockout;

    flk_key_match #(
        .DATA_W (DATA_W),
        .KEY_LEN(KEY_LEN),
        .IDX_W  (IDX_W),
        .KEYS   (KEYS)
    ) u_match (
        .idx_i  (idx),
        .data_i (key_data_i),
        .match_o(key_match)
    );

    flk_seq #(
        .KEY_LEN(KEY_LEN),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (key_wr_i),
        .key_match_i(key_match),
        .op_req_i   (op_req_i),
        .idx_o      (idx),
        .op_ok_o    (op_ok),
        .armed_o    (armed),
        .lockout_o  (lockout)
    );

    flk_permit u_permit (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_ok_i (op_ok),
        .permit_o(permit_o)
    );

    assign rd_go_o   = rd_req_i;
    assign lockout_o = lockout;
    assign status_o  = {lockout, armed, idx};

    assert_locked_no_permit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> !permit_o);

    assert_permit_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_req_i && !armed |=> !permit_o);

endmodule

// File: tb/flash_key_guard_tb.sv
module flash_key_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_wr_i = 1'b0;
    logic [7:0] key_data_i = 8'h00;
    logic       op_req_i = 1'b0;
    logic       rd_req_i = 1'b0;
    logic       rd_go_o;
    logic       permit_o;
    logic       lockout_o;
    logic [2:0] status_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit       m_lock;
    bit       m_open;
    bit       m_idx;
    bit       m_permit;

    always #4 clk = ~clk;

    flash_key_guard u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr_i  (key_wr_i),
        .key_data_i(key_data_i),
        .op_req_i  (op_req_i),
        .rd_req_i  (rd_req_i),
        .rd_go_o   (rd_go_o),
        .permit_o  (permit_o),
        .lockout_o (lockout_o),
        .status_o  (status_o)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] key_byte(input bit i);
        return i ? 8'hF1 : 8'hA5;
    endfunction

    task automatic model_reset();
        m_lock = 0; m_open = 0; m_idx = 0; m_permit = 0;
    endtask

    task automatic model_step(input bit kw, input bit [7:0] kd, input bit op);
        m_permit = 0;
        if (m_lock) return;
        if (op) begin
            if (m_open) m_permit = 1;
            else m_lock = 1;
            m_open = 0; m_idx = 0;
        end else if (kw) begin
            if (m_open || kd != key_byte(m_idx)) begin
                m_lock = 1; m_open = 0; m_idx = 0;
            end else if (m_idx == 1) begin
                m_open = 1; m_idx = 0;
            end else begin
                m_idx = 1;
            end
        end
    endtask

    task automatic check_outputs(input string req);
        check(permit_o, m_permit, {req, " permit"});
        check(lockout_o, m_lock, {req, " lockout"});
        check(status_o, {m_lock, m_open, m_idx}, {req, " status"});
    endtask

    task automatic step(input bit kw, input bit [7:0] kd, input bit op, input bit rd,
                        input string req);
        key_wr_i = kw; key_data_i = kd; op_req_i = op; rd_req_i = rd;
        #1;
        check(rd_go_o, rd, "R7 read pass-through");
        @(posedge clk);
        model_step(kw, kd, op);
        @(negedge clk);
        key_wr_i = 0; op_req_i = 0; rd_req_i = 0;
        check_outputs(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; key_wr_i = 0; op_req_i = 0; rd_req_i = 0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_outputs("R1 reset state");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        do_reset();

        // R2, R8, R5: normal unlock and single consumption
        step(1, 8'hA5, 0, 0, "R2 first byte");
        check(status_o, 3'b001, "R2 status after first byte");
        step(0, 8'h00, 0, 1, "R8 read between bytes");
        step(0, 8'h00, 0, 0, "R8 idle between bytes");
        check(status_o, 3'b001, "R8 status held");
        step(1, 8'hF1, 0, 0, "R2 second byte");
        check(status_o, 3'b010, "R2 armed status");
        step(0, 8'h00, 1, 0, "R5 granted request");
        check(permit_o, 1, "R5 permit pulse");
        check(status_o, 3'b000, "R5 relocked");
        step(0, 8'h00, 0, 0, "R5 permit drops");
        check(permit_o, 0, "R5 one cycle only");

        // R4 then R6
        step(0, 8'h00, 1, 1, "R4 request without key");
        check(status_o, 3'b100, "R4 lockout status");
        step(1, 8'hA5, 0, 1, "R6 key ignored");
        step(1, 8'hF1, 0, 0, "R6 key ignored");
        step(0, 8'h00, 1, 0, "R6 request ignored");
        check(permit_o, 0, "R6 no permit in lockout");
        do_reset();

        // R3 wrong second byte, wrong first byte, key while armed
        step(1, 8'hA5, 0, 0, "R3 setup");
        step(1, 8'h00, 0, 0, "R3 wrong second byte");
        check(lockout_o, 1, "R3 lockout after bad second");
        do_reset();
        step(1, 8'hF1, 0, 0, "R3 wrong first byte");
        check(status_o, 3'b100, "R3 lockout after bad first");
        do_reset();
        step(1, 8'hA5, 0, 0, "R3 setup");
        step(1, 8'hF1, 0, 0, "R3 setup");
        step(1, 8'hA5, 0, 0, "R3 key while armed");
        check(lockout_o, 1, "R3 lockout on extra key");
        do_reset();

        // R4 request mid-sequence
        step(1, 8'hA5, 0, 0, "R4 setup");
        step(0, 8'h00, 1, 0, "R4 request mid-sequence");
        check(lockout_o, 1, "R4 mid-sequence lockout");
        do_reset();

        // R9 simultaneous key write and request
        step(1, 8'hA5, 0, 0, "R9 setup");
        step(1, 8'hF1, 0, 0, "R9 setup");
        step(1, 8'h00, 1, 0, "R9 key and request together");
        check(permit_o, 1, "R9 permit granted");
        check(status_o, 3'b000, "R9 key byte discarded");
        step(0, 8'h00, 1, 0, "R5 second request needs new key");
        check(lockout_o, 1, "R5 reuse locks out");
        do_reset();

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit [7:0] kd;
            bit       kw, op, rd;
            int       sel;
            if (n % 150 == 149) do_reset();
            sel = $urandom_range(0, 9);
            kd  = (sel < 4) ? 8'hA5 : (sel < 8) ? 8'hF1 : 8'($urandom);
            kw  = ($urandom_range(0, 2) == 0);
            op  = ($urandom_range(0, 5) == 0);
            rd  = $urandom_range(0, 1);
            step(kw, kd, op, rd, "R2-random R3 R4 R5 R6 R8 R9 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule